// File: doc/BRIEF.md
# Standby Mode Power Controller

This block decides when a small microcontroller may drop into one of its two low-power states and when it must come back out. Software writes a sleep request bit, a stop request bit, or both. The write takes effect only when no peripheral is raising a live interrupt. Sleep gates the CPU clock and leaves the oscillator and the peripherals running. Stop also switches the main oscillator off. Any live interrupt request ends standby, whether or not the CPU would accept that interrupt. Leaving stop first passes through an oscillator-stabilization wait, and only after that wait is the CPU clock released.

The wait is timed by an internal time-base counter that advances on a prescaled tick input. The counter restarts from zero when the oscillator is re-enabled, and the wait ends when a selectable counter bit goes high. The same counter drives a time-base interval request. That request keeps firing during the stabilization wait unless software has cleared its enable.

At the moment of wake, the block compares the most urgent live request against the CPU's current interrupt level and its enable flag. From that comparison it tells the CPU either to branch to the interrupt routine or to resume at the instruction after the standby write.

Top module: `standby_ctrl`

## Requirements
- R1: An interrupt request counts as live only when its 2-bit level is not 11. Level 00 is the most urgent. A request at level 11 neither blocks standby entry nor wakes the block.
- R2: A write that sets the sleep or stop bit while a live request is present is discarded. The mode stays run (code 0), and it is still run after that request goes away.
- R3: With no live request, a sleep-only write puts the mode at sleep (code 1) on the next clock edge, with osc_en 1 and cpu_clk_en 0. A write with the stop bit set, alone or together with the sleep bit, puts the mode at stop (code 2) with osc_en 0 and cpu_clk_en 0.
- R4: A live request during sleep returns the mode to run on the next edge. On that edge cpu_clk_en rises and wake pulses high for exactly one cycle. There is no stabilization wait.
- R5: A live request during stop moves the mode to stabilization wait (code 3) on the next edge. In that mode osc_en is 1 and cpu_clk_en stays 0.
- R6: With wait select s, the time-base counter restarts at the entry to the wait. The mode returns to run, with a one-cycle wake pulse, on the edge after the counter reaches 2^(WAIT_TAP_BASE+2s) ticks. With a tick on every cycle, the wait is observed for 2^(WAIT_TAP_BASE+2s)+1 cycles. Without ticks the wait does not advance.
- R7: take_irq is high in the wake cycle exactly when cpu_ie is 1 and the numerically smallest live level is strictly below cpu_il. At all other times take_irq is 0.
- R8: sleep_bit reads 1 only while the mode is sleep, and stop_bit reads 1 only while the mode is stop. Both read 0 once standby has ended.
- R9: While tbi_en is 1 and the oscillator runs, tbi_req pulses once every 2^(TBI_TAP_BASE+tbi_sel) ticks, including during the stabilization wait. tbi_req never pulses when tbi_en is 0 or when the mode is stop.
- R10: Standby writes made while the mode is not run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the standby request bits |
| wr_sleep | input | 1 | Sleep request bit written |
| wr_stop | input | 1 | Stop request bit written |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_lvl | input | 2*N_IRQ | 2-bit level per request, source i at bits [2i+1:2i] |
| cpu_il | input | 2 | CPU current interrupt level |
| cpu_ie | input | 1 | CPU interrupt enable flag |
| tb_tick | input | 1 | Prescaled tick that advances the time-base counter |
| wait_sel | input | 2 | Stabilization wait select |
| tbi_sel | input | 2 | Time-base interval select |
| tbi_en | input | 1 | Time-base interval request enable |
| mode | output | 2 | 0 run, 1 sleep, 2 stop, 3 stabilization wait |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| wake | output | 1 | One-cycle pulse when the CPU clock is released |
| take_irq | output | 1 | In the wake cycle: branch to the interrupt routine (1) or resume (0) |
| sleep_bit | output | 1 | Readback of the sleep request bit |
| stop_bit | output | 1 | Readback of the stop request bit |
| tbi_req | output | 1 | Time-base interval request pulse |

## Verification
The bench walks every request level through both an entry attempt and a wake attempt. If the design qualified level 11 as live, it would refuse sleep entry for that level instead of entering, and a design that latched a refused write would drift into sleep after the request cleared. Every wake level is crossed with every CPU level and both enable values, plus one case with two requests of different urgency, so an off-by-one or reversed level comparison shows up as a wrong take_irq. Each wait select is crossed with every interval choice that fits inside it, comparing wait length and interval pulse count against powers of two. A counter that failed to restart, or a wrong tap, changes both counts, and an interval request left ungated in stop or ignoring its enable adds pulses.

// File: rtl/sbc_pkg.sv
// Shared types for the standby controller.
package sbc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_STOP  = 2'd2,
        MODE_WAIT  = 2'd3
    } sbc_mode_e;
endpackage

// File: rtl/sbc_irq_eval.sv
// Qualifies interrupt requests for standby purposes and finds the most
// urgent live level. Assumes 00 is most urgent and 11 means disabled.
// best_lvl reads 11 when nothing is live.
module sbc_irq_eval #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [2*N_IRQ-1:0] irq_lvl,
    output logic               pending,
    output logic [1:0]         best_lvl
);
    logic [N_IRQ-1:0] live;

    // One qualifier per source: a request counts only when its level is not 11.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_live
        assign live[g] = irq_req[g] && (irq_lvl[2*g +: 2] != 2'b11);
    end

    // Any live source blocks entry and ends standby.
    assign pending = |live;

    // Minimum level over the live sources.
    always_comb begin
        best_lvl = 2'b11;
        for (int i = 0; i < N_IRQ; i++) begin
            if (live[i] && (irq_lvl[2*i +: 2] < best_lvl)) best_lvl = irq_lvl[2*i +: 2];
        end
    end
endmodule

// File: rtl/sbc_timebase.sv
// Time-base counter: it advances on tb_tick while the oscillator runs and
// clears on restart. It provides the stabilization-wait tap and the
// interval request. Assumes the width covers the largest tap of both selects.
module sbc_timebase #(
    parameter int WAIT_TAP_BASE = 12,
    parameter int TBI_TAP_BASE  = 8,
    parameter int CNT_W         = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_tick,
    input  logic       run_en,
    input  logic       restart,
    input  logic [1:0] wait_sel,
    input  logic [1:0] tbi_sel,
    input  logic       tbi_en,
    output logic       wait_done,
    output logic       tbi_req
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tbi_mask;
    int unsigned      wait_tap;

    // Tick counter, restarted when the oscillator comes back on.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart)          cnt <= '0;
        else if (run_en && tb_tick) cnt <= cnt + 1'b1;
    end

    // The wait ends once the selected tap bit is set.
    always_comb begin
        wait_tap  = WAIT_TAP_BASE + 2 * int'(wait_sel);
        wait_done = cnt[wait_tap];
    end

    // Low bits that must all be ones for the interval to roll over.
    assign tbi_mask = (CNT_W'(1) << (TBI_TAP_BASE + int'(tbi_sel))) - 1'b1;

    // Interval pulse on the tick that rolls the selected low bits over.
    always_ff @(posedge clk) begin
        if (!rst_n) tbi_req <= 1'b0;
        else        tbi_req <= tbi_en && run_en && tb_tick && !restart
                               && ((cnt & tbi_mask) == tbi_mask);
    end
endmodule

// File: rtl/sbc_mode_fsm.sv
// Mode sequencer: run, sleep, stop and stabilization wait. It refuses entry
// while a request is live and forms the wake pulse and the branch decision.
// Assumes pending and best_lvl come from combinational qualification.
module sbc_mode_fsm
    import sbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sleep,
    input  logic       wr_stop,
    input  logic       pending,
    input  logic [1:0] best_lvl,
    input  logic [1:0] cpu_il,
    input  logic       cpu_ie,
    input  logic       wait_done,
    output sbc_mode_e  mode,
    output logic       restart,
    output logic       wake,
    output logic       take_irq,
    output logic       sleep_bit,
    output logic       stop_bit
);
    sbc_mode_e mode_nxt;
    logic      wake_nxt;

    // Next-mode decision; stop wins when both bits are written.
    always_comb begin
        mode_nxt = mode;
        wake_nxt = 1'b0;
        restart  = 1'b0;
        unique case (mode)
            MODE_RUN: if (wr_en && (wr_sleep || wr_stop) && !pending)
                          mode_nxt = wr_stop ? MODE_STOP : MODE_SLEEP;
            MODE_SLEEP: if (pending) begin
                          mode_nxt = MODE_RUN;
                          wake_nxt = 1'b1;
                      end
            MODE_STOP: if (pending) begin
                          mode_nxt = MODE_WAIT;
                          restart  = 1'b1;
                      end
            MODE_WAIT: if (wait_done) begin
                          mode_nxt = MODE_RUN;
                          wake_nxt = 1'b1;
                      end
            default: mode_nxt = MODE_RUN;
        endcase
    end

    // State, wake pulse, branch decision and request-bit readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_RUN;
            wake      <= 1'b0;
            take_irq  <= 1'b0;
            sleep_bit <= 1'b0;
            stop_bit  <= 1'b0;
        end else begin
            mode      <= mode_nxt;
            wake      <= wake_nxt;
            take_irq  <= wake_nxt && cpu_ie && (best_lvl < cpu_il);
            sleep_bit <= (mode_nxt == MODE_SLEEP);
            stop_bit  <= (mode_nxt == MODE_STOP);
        end
    end
endmodule

// File: rtl/standby_ctrl.sv
// Standby mode power controller top. It ties together request qualification,
// the mode sequencer and the time-base counter. Assumes clk is the base
// clock, which keeps running while the CPU clock is gated.
module standby_ctrl
    import sbc_pkg::*;
#(
    parameter int N_IRQ         = 4,
    parameter int WAIT_TAP_BASE = 12,
    parameter int TBI_TAP_BASE  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sleep,
    input  logic               wr_stop,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [2*N_IRQ-1:0] irq_lvl,
    input  logic [1:0]         cpu_il,
    input  logic               cpu_ie,
    input  logic               tb_tick,
    input  logic [1:0]         wait_sel,
    input  logic [1:0]         tbi_sel,
    input  logic               tbi_en,
    output logic [1:0]         mode,
    output logic               osc_en,
    output logic               cpu_clk_en,
    output logic               wake,
    output logic               take_irq,
    output logic               sleep_bit,
    output logic               stop_bit,
    output logic               tbi_req
);
    localparam int WAIT_W = WAIT_TAP_BASE + 7;
    localparam int TBI_W  = TBI_TAP_BASE + 4;
    localparam int CNT_W  = (WAIT_W > TBI_W) ? WAIT_W : TBI_W;

    logic      pending;
    logic [1:0] best_lvl;
    logic      restart;
    logic      wait_done;
    sbc_mode_e mode_q;

    sbc_irq_eval #(.N_IRQ(N_IRQ)) u_eval (
        .irq_req  (irq_req),
        .irq_lvl  (irq_lvl),
        .pending  (pending),
        .best_lvl (best_lvl)
    );

    sbc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sleep  (wr_sleep),
        .wr_stop   (wr_stop),
        .pending   (pending),
        .best_lvl  (best_lvl),
        .cpu_il    (cpu_il),
        .cpu_ie    (cpu_ie),
        .wait_done (wait_done),
        .mode      (mode_q),
        .restart   (restart),
        .wake      (wake),
        .take_irq  (take_irq),
        .sleep_bit (sleep_bit),
        .stop_bit  (stop_bit)
    );

    sbc_timebase #(
        .WAIT_TAP_BASE (WAIT_TAP_BASE),
        .TBI_TAP_BASE  (TBI_TAP_BASE),
        .CNT_W         (CNT_W)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tb_tick   (tb_tick),
        .run_en    (osc_en),
        .restart   (restart),
        .wait_sel  (wait_sel),
        .tbi_sel   (tbi_sel),
        .tbi_en    (tbi_en),
        .wait_done (wait_done),
        .tbi_req   (tbi_req)
    );

    // Mode decode to the clock controls.
    assign mode       = mode_q;
    assign osc_en     = (mode_q != MODE_STOP);
    assign cpu_clk_en = (mode_q == MODE_RUN);
endmodule

// File: rtl/standby_ctrl_checker.sv
// Port-level properties of the standby controller, bound to every instance.
// Assumes the mode codes 0 run, 1 sleep, 2 stop, 3 wait.
module sbc_checker #(
    parameter int N_IRQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_sleep,
    input logic               wr_stop,
    input logic [N_IRQ-1:0]   irq_req,
    input logic [2*N_IRQ-1:0] irq_lvl,
    input logic [1:0]         mode,
    input logic               osc_en,
    input logic               cpu_clk_en,
    input logic               wake,
    input logic               take_irq,
    input logic               sleep_bit,
    input logic               stop_bit,
    input logic               tbi_req
);
    logic live_any;

    // Independent view of whether any request is live at the ports.
    always_comb begin
        live_any = 1'b0;
        for (int i = 0; i < N_IRQ; i++)
            if (irq_req[i] && irq_lvl[2*i +: 2] != 2'b11) live_any = 1'b1;
    end

    AST_REFUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && wr_en && (wr_sleep || wr_stop) && live_any) |=> (mode == 2'd0)); // R2
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && wr_en && wr_stop && !live_any) |=> (mode == 2'd2 && !osc_en)); // R3
    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && live_any) |=> (mode == 2'd0 && wake && cpu_clk_en)); // R4
    AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && live_any) |=> (mode == 2'd3 && osc_en && !cpu_clk_en)); // R5
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake); // R4
    AST_TAKE_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> wake); // R7
    AST_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 || mode == 2'd3) |-> (!sleep_bit && !stop_bit)); // R8
    AST_NO_TBI_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) == 2'd2) |-> !tbi_req); // R9
    AST_IGNORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !live_any) |=> (mode == 2'd2)); // R10
endmodule

bind standby_ctrl sbc_checker #(.N_IRQ(N_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sleep   (wr_sleep),
    .wr_stop    (wr_stop),
    .irq_req    (irq_req),
    .irq_lvl    (irq_lvl),
    .mode       (mode),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .wake       (wake),
    .take_irq   (take_irq),
    .sleep_bit  (sleep_bit),
    .stop_bit   (stop_bit),
    .tbi_req    (tbi_req)
);

// File: tb/sim_standby_ctrl.sv
// Sweeps levels, CPU settings, wait and interval selects on a small build.
module sim_standby_ctrl;
    localparam int N  = 3;
    localparam int WB = 2;
    localparam int IB = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, wr_sleep = 1'b0, wr_stop = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [2*N-1:0] irq_lvl = '1;
    logic [1:0]   cpu_il = 2'd0;
    logic         cpu_ie = 1'b0;
    logic         tb_tick = 1'b1;
    logic [1:0]   wait_sel = 2'd0, tbi_sel = 2'd0;
    logic         tbi_en = 1'b0;
    logic [1:0]   mode;
    logic         osc_en, cpu_clk_en, wake, take_irq, sleep_bit, stop_bit, tbi_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    standby_ctrl #(.N_IRQ(N), .WAIT_TAP_BASE(WB), .TBI_TAP_BASE(IB)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_bits(input logic s, input logic p);
        wr_en = 1'b1; wr_sleep = s; wr_stop = p;
        step();
        wr_en = 1'b0; wr_sleep = 1'b0; wr_stop = 1'b0;
    endtask

    // Wake from sleep through source 1 at level 00.
    task automatic wake_sleep();
        irq_req[1] = 1'b1; irq_lvl[3:2] = 2'b00;
        step();
        irq_req[1] = 1'b0; irq_lvl[3:2] = 2'b11;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset mode", mode, 0);
        chk("R3 reset osc", osc_en, 1);
        chk("R3 reset clk", cpu_clk_en, 1);
        chk("R8 reset bits", {sleep_bit, stop_bit}, 0);

        // R1/R2: entry attempt under each level on source 0.
        for (int l = 0; l < 4; l++) begin
            irq_req[0] = 1'b1; irq_lvl[1:0] = 2'(l);
            write_bits(1'b1, 1'b0);
            chk("R1 R2 entry vs level", mode, (l == 3) ? 1 : 0);
            irq_req[0] = 1'b0; irq_lvl[1:0] = 2'b11;
            repeat (3) step();
            chk("R2 refused write not latched", mode, (l == 3) ? 1 : 0);
            if (l == 3) begin
                chk("R8 sleep bit", sleep_bit, 1);
                chk("R3 sleep osc", osc_en, 1);
                chk("R3 sleep clk", cpu_clk_en, 0);
                wake_sleep();
                chk("R4 sleep wake mode", mode, 0);
                chk("R4 wake pulse", wake, 1);
                chk("R8 sleep bit cleared", sleep_bit, 0);
                step();
                chk("R4 wake single cycle", wake, 0);
            end
        end

        // R1: level 11 does not wake.
        write_bits(1'b1, 1'b0);
        irq_req[2] = 1'b1; irq_lvl[5:4] = 2'b11;
        repeat (3) step();
        chk("R1 level 11 no wake", mode, 1);
        irq_req[2] = 1'b0;
        wake_sleep();
        step();

        // R3/R10: stop alone and with sleep; writes in stop are ignored.
        for (int b = 0; b < 2; b++) begin
            write_bits(b[0], 1'b1);
            chk("R3 stop entry", mode, 2);
            chk("R3 stop osc off", osc_en, 0);
            chk("R8 stop bits", {sleep_bit, stop_bit}, 1);
            write_bits(1'b1, 1'b0);
            chk("R10 write in stop ignored", mode, 2);
            irq_req[0] = 1'b1; irq_lvl[1:0] = 2'b10;
            step();
            irq_req[0] = 1'b0; irq_lvl[1:0] = 2'b11;
            chk("R5 stop exit to wait", mode, 3);
            chk("R5 wait osc on", osc_en, 1);
            chk("R5 wait clk gated", cpu_clk_en, 0);
            chk("R8 stop bit cleared", stop_bit, 0);
            write_bits(1'b0, 1'b1);
            chk("R10 write in wait ignored", mode, 3);
            repeat (20) step();
            chk("R6 wait ends", mode, 0);
        end

        // R7: branch decision swept over level, CPU level and enable.
        for (int l = 0; l < 3; l++)
            for (int il = 0; il < 4; il++)
                for (int ie = 0; ie < 2; ie++) begin
                    write_bits(1'b1, 1'b0);
                    cpu_il = 2'(il); cpu_ie = ie[0];
                    irq_req[2] = 1'b1; irq_lvl[5:4] = 2'(l);
                    step();
                    irq_req[2] = 1'b0; irq_lvl[5:4] = 2'b11;
                    chk("R4 wake", wake, 1);
                    chk("R7 take", take_irq, (ie == 1 && l < il) ? 1 : 0);
                    step();
                    chk("R7 take low outside wake", take_irq, 0);
                end

        // R7: the most urgent of two requests decides.
        write_bits(1'b1, 1'b0);
        cpu_il = 2'd1; cpu_ie = 1'b1;
        irq_req[0] = 1'b1; irq_lvl[1:0] = 2'b10;
        irq_req[1] = 1'b1; irq_lvl[3:2] = 2'b00;
        step();
        irq_req = '0; irq_lvl = '1;
        chk("R7 min level wins", take_irq, 1);
        step();

        // R6/R9: wait length and interval pulses for every fitting pair.
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 4; t++) begin
                int waitc, pulses, guard, expp;
                if (1 + t > WB + 2 * s) continue;
                write_bits(1'b0, 1'b1);
                wait_sel = 2'(s); tbi_sel = 2'(t); tbi_en = t[0] ^ s[0];
                cpu_il = 2'd3; cpu_ie = s[0];
                irq_req[0] = 1'b1; irq_lvl[1:0] = 2'b00;
                step();
                waitc = (mode == 2'd3) ? 1 : 0;
                pulses = tbi_req ? 1 : 0;
                guard = 0;
                while (guard < 2000) begin
                    guard++;
                    step();
                    pulses += tbi_req ? 1 : 0;
                    if (mode == 2'd3) waitc++;
                    else break;
                end
                chk("R6 wait cycles", waitc, (1 << (WB + 2 * s)) + 1);
                chk("R6 wake after wait", wake, 1);
                chk("R7 take after stop", take_irq, s % 2);
                expp = tbi_en ? (1 << (WB + 2 * s - IB - t)) : 0;
                chk("R9 interval pulses", pulses, expp);
                irq_req[0] = 1'b0; irq_lvl[1:0] = 2'b11; tbi_en = 1'b0;
                step();
            end

        // R6: the wait does not advance without ticks.
        wait_sel = 2'd0;
        write_bits(1'b0, 1'b1);
        tb_tick = 1'b0;
        irq_req[0] = 1'b1; irq_lvl[1:0] = 2'b01;
        step();
        irq_req[0] = 1'b0; irq_lvl[1:0] = 2'b11;
        repeat (30) step();
        chk("R6 wait held without ticks", mode, 3);
        tb_tick = 1'b1;
        repeat (8) step();
        chk("R6 wait completes with ticks", mode, 0);

        // R9: interval in run mode, enabled and disabled.
        for (int e = 0; e < 2; e++) begin
            int cnt = 0;
            tbi_sel = 2'd0; tbi_en = e[0];
            step();
            for (int k = 0; k < 16; k++) begin
                step();
                cnt += tbi_req ? 1 : 0;
            end
            chk("R9 run interval count", cnt, e ? 8 : 0);
        end
        tbi_en = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule